// File: doc/BRIEF.md
# Microcoded Instruction Fetch Unit

This block is the front end of a small 16-bit processor. It keeps a program counter, a memory address register, a memory data register and an instruction register. A three-state microcoded controller runs the fetch of one instruction after another. The controller's state number indexes a control store. Each word of that store supplies the register load enables, the memory read strobe and the two-bit code that picks the source of the next program counter value.

Each fetch has three steps, visited in a fixed order:
- **State 18:** the current PC moves into the address register, and PC+1 is written back into the PC on the same edge.
- **State 33:** the controller holds while the read strobe is high. It keeps capturing the memory's read data until the memory reports ready.
- **State 35:** the captured word moves into the instruction register, and the controller returns to state 18 to fetch the next address.

The memory is outside the block and answers combinationally from the address output.

Top module: `fetch_useq`

## Requirements
- R1: While `rst` is high at a rising edge, the PC, address, data and instruction registers become 0, the controller goes to state 18, and `mem_rd` is 0.
- R2: `mem_rd` is 1 only in state 33. After reset is released it rises one cycle later. After a cycle with `mem_rd` and `mem_ready` both 1, it is 0 for exactly two cycles and then 1 again.
- R3: In state 18, one edge loads `mem_addr` with the old PC and loads `pc_q` with the old PC plus 1. The PC source code for this state is 2'b00, which is the incrementer input of the four-way PC multiplexer.
- R4: While `mem_rd` is 1 and `mem_ready` is 0, the controller stays in state 33. `mem_rd` stays 1 and `mem_addr` does not change.
- R5: The read data present in the cycle where `mem_rd` and `mem_ready` are both 1 appears on `ir_q` two edges later.
- R6: After state 35 the controller returns to state 18, so successive fetches read addresses 0, 1, 2, … in order.
- R7: The PC changes only on the edge that leaves state 18. The control store holds the PC load enable at 0 in states 33 and 35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all registers load on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 16 | Read data from memory |
| mem_ready | input | 1 | Memory read complete |
| mem_addr | output | 16 | Memory address, driven from the address register |
| mem_rd | output | 1 | Memory read request |
| ir_q | output | 16 | Instruction register |
| pc_q | output | 16 | Program counter |

## Verification
Suppose the controller takes a wrong state or reads a wrong control-store word. The read strobe would then have the wrong pulse pattern or the wrong length within one fetch, because its rhythm is fixed at two low cycles between reads. A wrong PC source code or load enable would show up at once in the PC at the next read request, which no longer sits one above the address output. A dropped or misrouted data capture would put the wrong word on the instruction register two edges after the ready cycle. The scoreboard compares the expected word, PC and address against the ports at that exact point for every fetch. It does this for ready delays from zero to many cycles.

// File: rtl/fetch_useq.sv
module fetch_useq #(
  parameter int W = 16,
  parameter int SW = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ready,
  output logic [W-1:0] mem_addr,
  output logic         mem_rd,
  output logic [W-1:0] ir_q,
  output logic [W-1:0] pc_q
);
  localparam logic [SW-1:0] S_ADDR = SW'(18);
  localparam logic [SW-1:0] S_READ = SW'(33);
  localparam logic [SW-1:0] S_INSN = SW'(35);
  localparam int CW = 7;

  logic [SW-1:0] state, state_nx;
  logic [CW-1:0] cword;
  logic          ld_mar, ld_pc, ld_mdr, ld_ir;
  logic [1:0]    pc_sel;
  logic [W-1:0]  mar, mdr, pc_in;

  always_comb begin
    cword = '0;
    case (state)
      S_ADDR: cword = 7'b1100_0_00;
      S_READ: cword = 7'b0010_1_00;
      S_INSN: cword = 7'b0001_0_00;
      default: cword = '0;
    endcase
  end

  assign {ld_mar, ld_pc, ld_mdr, ld_ir, mem_rd, pc_sel} = cword;

  always_comb begin
    case (state)
      S_ADDR:  state_nx = S_READ;
      S_READ:  state_nx = mem_ready ? S_INSN : S_READ;
      default: state_nx = S_ADDR;
    endcase
  end

  always_comb begin
    case (pc_sel)
      2'b00:   pc_in = pc_q + W'(1);
      2'b01:   pc_in = '0;
      2'b10:   pc_in = '0;
      default: pc_in = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_ADDR;
      pc_q  <= '0;
      mar   <= '0;
      mdr   <= '0;
      ir_q  <= '0;
    end else begin
      state <= state_nx;
      if (ld_pc)  pc_q <= pc_in;
      if (ld_mar) mar  <= pc_q;
      if (ld_mdr) mdr  <= mem_rdata;
      if (ld_ir)  ir_q <= mdr;
    end
  end

  assign mem_addr = mar;
endmodule

// File: rtl/fetch_useq_chk.sv
module fetch_useq_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] mem_rdata,
  input logic         mem_ready,
  input logic [W-1:0] mem_addr,
  input logic         mem_rd,
  input logic [W-1:0] ir_q,
  input logic [W-1:0] pc_q
);
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && mem_addr == '0 && ir_q == '0 && !mem_rd));

  assert_read_end_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_ready) |=> !mem_rd ##1 !mem_rd ##1 mem_rd);

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd) |-> (pc_q == mem_addr + W'(1)));

  assert_wait_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  assert_ir_load_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_ready) |=> ##1 (ir_q == $past(mem_rdata, 2)));

  assert_pc_hold_R7: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> $stable(pc_q));
endmodule

bind fetch_useq fetch_useq_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_rd(mem_rd), .ir_q(ir_q), .pc_q(pc_q)
);

// File: tb/test_fetch_useq.sv
`timescale 1ns/1ps
module test_fetch_useq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata, mem_addr, ir_q, pc_q;
  logic        mem_rd;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { logic [15:0] ir, pc, addr; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return (a * 16'h03b1) ^ 16'h5a5a;
  endfunction

  assign mem_rdata = mem_word(mem_addr);

  fetch_useq i_fetch_useq (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .ir_q(ir_q), .pc_q(pc_q)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fetch_one(input logic [15:0] k, input int waits);
    exp_t e;
    e.ir = mem_word(k); e.pc = k + 16'd1; e.addr = k;
    q.push_back(e);
    do begin @(posedge clk); #1; end while (!mem_rd);
    for (int i = 0; i < waits; i++) begin
      @(posedge clk); #1;
      chk("R4 rd held while waiting", {15'd0, mem_rd}, 16'd1);
      chk("R4 addr held while waiting", mem_addr, k);
      chk("R7 pc held while waiting", pc_q, k + 16'd1);
    end
    mem_ready = 1'b1;
    @(posedge clk); #1;
    mem_ready = 1'b0;
  endtask

  logic s1 = 1'b0, s2 = 1'b0;
  always @(negedge clk) begin
    if (s2) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5: actual unexpected fetch expected none");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk("R5 ir word", ir_q, e.ir);
        chk("R6 pc after fetch", pc_q, e.pc);
        chk("R6 address sequence", mem_addr, e.addr);
        chk("R2 rd low in return state", {15'd0, mem_rd}, 16'd0);
      end
    end
    s2 = s1;
    s1 = mem_rd && mem_ready;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pc reset", pc_q, 16'd0);
    chk("R1 addr reset", mem_addr, 16'd0);
    chk("R1 ir reset", ir_q, 16'd0);
    chk("R1 rd reset", {15'd0, mem_rd}, 16'd0);
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    chk("R2 rd low in first state", {15'd0, mem_rd}, 16'd0);
    @(negedge clk);
    chk("R2 rd rises after first state", {15'd0, mem_rd}, 16'd1);
    chk("R3 addr takes old pc", mem_addr, 16'd0);
    chk("R3 pc incremented", pc_q, 16'd1);
    for (int k = 0; k < 24; k++)
      fetch_one(16'(k), (k == 9) ? 30 : (k * 3) % 5);
    repeat (4) @(posedge clk);
    #1;
    chk("R6 queue drained", 16'(q.size()), 16'd0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule